// File: doc/BRIEF.md
# Oversampling Offset and Gain Trim Controller

This block is the digital half of a self-calibration loop for one converter section. In every conversion frame the section runs two extra comparisons: one against a zero reference for offset, and one against a gain reference. Each comparison gives one comparator decision. The block treats every decision as a single vote. It adds the votes up in a signed integrator for each loop. It moves the matching trim code only after the votes lean one way by a set margin. So a single noisy decision never moves a trim. The trims settle by oversampling.

Each trim code is 14 bits wide. The low 4 bits sit below one converter LSB, so one trim step is one sixteenth of an LSB. The two loops start on their own when reset is released. They keep correcting for as long as the clock runs, including after the calibrated flag has gone high. That flag goes high after a fixed number of clock cycles following reset. It tells the downstream logic that the trims have had time to settle.

Top module: `cal_trim_loop`

## Requirements
- R1: While `rst_n` is low, `offset_trim` equals parameter `OFS_INIT`, `gain_trim` equals `GAIN_INIT` and `cal_done` is 0. Both integrators are cleared.
- R2: On each rising edge where a loop's valid input is 1, that loop's integrator adds 1 when the decision input is 1 and subtracts 1 when it is 0. A run of votes whose running sum never reaches ±`THRESH` leaves the trim unchanged.
- R3: When a vote would bring the offset integrator to +`THRESH`, `offset_trim` drops by one code on that same edge and the integrator clears. When a vote would bring it to −`THRESH`, `offset_trim` rises by one code and the integrator clears.
- R4: The gain loop follows the same rule as R3, on `gc_vld`/`gc_hi` and `gain_trim`: +`THRESH` lowers the code and −`THRESH` raises it.
- R5: A trim code saturates and does not wrap. A downward step at 0 leaves it at 0, and an upward step at 2^`TRIM_W`−1 leaves it there. The integrator still clears in both cases.
- R6: `cal_done` is 0 after `CAL_CYCLES`−1 rising edges following the release of reset. It is 1 from the `CAL_CYCLES`-th edge onward and stays 1 until the next reset.
- R7: Both loops keep updating their trims after `cal_done` has gone high.
- R8: A trim never changes on an edge where its loop's valid input is 0. The decision input is ignored on such edges.
- R9: The two loops are independent: votes on one loop never change the other loop's trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| az_vld | input | 1 | Offset (zero-reference) comparison slot carries a decision |
| az_hi | input | 1 | Offset comparator decision: 1 = above, 0 = below |
| gc_vld | input | 1 | Gain-reference comparison slot carries a decision |
| gc_hi | input | 1 | Gain comparator decision: 1 = above, 0 = below |
| offset_trim | output | TRIM_W | Offset trim code, 4 bits below one LSB |
| gain_trim | output | TRIM_W | Gain trim code, 4 bits below one LSB |
| cal_done | output | 1 | Calibration settle time has elapsed |

## Verification
A vote applied before a rising edge shows up in the trim at that same edge, because the integrator and the trim register are updated together. The bench therefore drives each vote half a period before the edge, updates its model at the edge, and compares both trims at the falling edge that follows. `cal_done` is due after exactly `CAL_CYCLES` edges counted from reset release. The bench counts edges and checks the flag on every cycle, so the cycles just before and just after the rise are both covered.

// File: rtl/cal_trim_pkg.sv
`timescale 1ns/1ps
package cal_trim_pkg;

  typedef enum logic [1:0] {
    NUDGE_NONE = 2'd0,
    NUDGE_UP   = 2'd1,
    NUDGE_DOWN = 2'd2
  } nudge_e;

  // one comparator decision counts as one vote
  function automatic int vote(input int acc, input logic hi);
    return hi ? acc + 1 : acc - 1;
  endfunction

  // excess of "above" votes pulls the trim down, and the reverse
  function automatic nudge_e judge(input int acc, input int thresh);
    if (acc >= thresh)  return NUDGE_DOWN;
    if (acc <= -thresh) return NUDGE_UP;
    return NUDGE_NONE;
  endfunction

  // saturating one-code move
  function automatic int apply_nudge(input int code, input nudge_e n, input int top);
    case (n)
      NUDGE_UP:   return (code >= top) ? code : code + 1;
      NUDGE_DOWN: return (code <= 0)   ? code : code - 1;
      default:    return code;
    endcase
  endfunction

endpackage

// File: rtl/trim_integrator.sv
`timescale 1ns/1ps
module trim_integrator
  import cal_trim_pkg::*;
#(
  parameter int THRESH = 16,
  parameter int INT_W  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_vld,
  input  logic sample_hi,
  output logic nudge_up,
  output logic nudge_dn
);

  logic signed [INT_W-1:0] acc_q;
  int     acc_sum;
  nudge_e verdict;

  always_comb begin
    acc_sum = vote(int'(acc_q), sample_hi);
    verdict = sample_vld ? judge(acc_sum, THRESH) : NUDGE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (sample_vld) begin
      if (verdict == NUDGE_NONE) acc_q <= INT_W'(acc_sum);
      else                       acc_q <= '0;
    end
  end

  assign nudge_up = (verdict == NUDGE_UP);
  assign nudge_dn = (verdict == NUDGE_DOWN);

endmodule

// File: rtl/trim_code_reg.sv
`timescale 1ns/1ps
module trim_code_reg
  import cal_trim_pkg::*;
#(
  parameter int unsigned TRIM_W = 14,
  parameter int unsigned INIT   = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nudge_up,
  input  logic              nudge_dn,
  output logic [TRIM_W-1:0] code
);

  localparam int CODE_TOP = (1 << TRIM_W) - 1;

  logic [TRIM_W-1:0] code_q;
  nudge_e            req;

  always_comb begin
    if (nudge_up)      req = NUDGE_UP;
    else if (nudge_dn) req = NUDGE_DOWN;
    else               req = NUDGE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= TRIM_W'(INIT);
    else        code_q <= TRIM_W'(apply_nudge(int'(code_q), req, CODE_TOP));
  end

  assign code = code_q;

endmodule

// File: rtl/settle_timer.sv
`timescale 1ns/1ps
module settle_timer #(
  parameter int unsigned CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CNT_W'(CYCLES - 1)) done_q <= 1'b1;
      else                             cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/cal_trim_loop.sv
`timescale 1ns/1ps
module cal_trim_loop #(
  parameter int unsigned TRIM_W     = 14,
  parameter int unsigned THRESH     = 16,
  parameter int unsigned CAL_CYCLES = 10000,
  parameter int unsigned OFS_INIT   = 1 << (TRIM_W - 1),
  parameter int unsigned GAIN_INIT  = 1 << (TRIM_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              az_vld,
  input  logic              az_hi,
  input  logic              gc_vld,
  input  logic              gc_hi,
  output logic [TRIM_W-1:0] offset_trim,
  output logic [TRIM_W-1:0] gain_trim,
  output logic              cal_done
);

  localparam int INT_W   = $clog2(THRESH) + 2;
  localparam int N_LOOPS = 2;   // index 0 = offset, 1 = gain

  logic [N_LOOPS-1:0] slot_vld;
  logic [N_LOOPS-1:0] slot_hi;
  logic [N_LOOPS-1:0] nudge_up;
  logic [N_LOOPS-1:0] nudge_dn;
  logic [TRIM_W-1:0]  code [N_LOOPS];

  assign slot_vld = {gc_vld, az_vld};
  assign slot_hi  = {gc_hi,  az_hi};

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
    trim_integrator #(
      .THRESH (int'(THRESH)),
      .INT_W  (INT_W)
    ) integ_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_vld (slot_vld[g]),
      .sample_hi  (slot_hi[g]),
      .nudge_up   (nudge_up[g]),
      .nudge_dn   (nudge_dn[g])
    );

    trim_code_reg #(
      .TRIM_W (TRIM_W),
      .INIT   ((g == 0) ? OFS_INIT : GAIN_INIT)
    ) code_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .nudge_up (nudge_up[g]),
      .nudge_dn (nudge_dn[g]),
      .code     (code[g])
    );
  end

  settle_timer #(
    .CYCLES (CAL_CYCLES)
  ) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (cal_done)
  );

  assign offset_trim = code[0];
  assign gain_trim   = code[1];

endmodule

// File: rtl/cal_trim_loop_chk.sv
`timescale 1ns/1ps
module cal_trim_loop_chk #(
  parameter int unsigned TRIM_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              az_vld,
  input logic              gc_vld,
  input logic [TRIM_W-1:0] offset_trim,
  input logic [TRIM_W-1:0] gain_trim,
  input logic              cal_done,
  input logic [1:0]        nudge_up,
  input logic [1:0]        nudge_dn
);

  p_ofs_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nudge_dn[0] && offset_trim != '0) |=> offset_trim == $past(offset_trim) - 1'b1);

  p_ofs_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nudge_up[0] && offset_trim != '1) |=> offset_trim == $past(offset_trim) + 1'b1);

  p_gain_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nudge_dn[1] && gain_trim != '0) |=> gain_trim == $past(gain_trim) - 1'b1);

  p_gain_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nudge_up[1] && gain_trim != '1) |=> gain_trim == $past(gain_trim) + 1'b1);

  p_ofs_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nudge_up[0] && offset_trim == '1) |=> offset_trim == '1);

  p_gain_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nudge_dn[1] && gain_trim == '0) |=> gain_trim == '0);

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  p_ofs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !az_vld |=> $stable(offset_trim));

  p_gain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gc_vld |=> $stable(gain_trim));

endmodule

bind cal_trim_loop cal_trim_loop_chk #(
  .TRIM_W (TRIM_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .az_vld      (az_vld),
  .gc_vld      (gc_vld),
  .offset_trim (offset_trim),
  .gain_trim   (gain_trim),
  .cal_done    (cal_done),
  .nudge_up    (nudge_up),
  .nudge_dn    (nudge_dn)
);

// File: tb/cal_trim_loop_tb_top.sv
`timescale 1ns/1ps
module cal_trim_loop_tb_top;

  localparam int TW   = 14;
  localparam int TH   = 16;
  localparam int NCAL = 10000;
  localparam int OI   = 2;
  localparam int GI   = 16381;
  localparam int TOPV = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          az_vld = 1'b0, az_hi = 1'b0, gc_vld = 1'b0, gc_hi = 1'b0;
  logic [TW-1:0] offset_trim, gain_trim;
  logic          cal_done;

  cal_trim_loop #(
    .TRIM_W (TW), .THRESH (TH), .CAL_CYCLES (NCAL),
    .OFS_INIT (OI), .GAIN_INIT (GI)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .az_vld (az_vld), .az_hi (az_hi), .gc_vld (gc_vld), .gc_hi (gc_hi),
    .offset_trim (offset_trim), .gain_trim (gain_trim), .cal_done (cal_done)
  );

  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  int m_acc [2];
  int m_trim [2];
  int moves_late = 0;

  task automatic expect_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model of one loop: count the vote, fire at the margin, clamp the code
  function automatic void model_vote(input int k, input bit v, input bit h);
    int s;
    if (!v) return;
    s = m_acc[k] + (h ? 1 : -1);
    if (s == TH) begin
      m_acc[k] = 0;
      if (m_trim[k] > 0) m_trim[k] = m_trim[k] - 1;
    end else if (s == -TH) begin
      m_acc[k] = 0;
      if (m_trim[k] < TOPV) m_trim[k] = m_trim[k] + 1;
    end else begin
      m_acc[k] = s;
    end
  endfunction

  // called at a falling edge: drive, clock, then sample at the next falling edge
  task automatic tick(input string tag_o, input string tag_g,
                      input bit v0, input bit h0, input bit v1, input bit h1);
    int prev_o;
    int prev_g;
    prev_o = offset_trim;
    prev_g = gain_trim;
    az_vld = v0; az_hi = h0; gc_vld = v1; gc_hi = h1;
    @(posedge clk);
    model_vote(0, v0, h0);
    model_vote(1, v1, h1);
    edges++;
    @(negedge clk);
    expect_eq(tag_o, int'(offset_trim), m_trim[0]);
    expect_eq(tag_g, int'(gain_trim), m_trim[1]);
    expect_eq("R6", int'(cal_done), (edges >= NCAL) ? 1 : 0);
    if (edges > NCAL && (int'(offset_trim) != prev_o || int'(gain_trim) != prev_g))
      moves_late++;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    az_vld = 0; az_hi = 0; gc_vld = 0; gc_hi = 0;
    m_acc[0] = 0; m_acc[1] = 0;
    m_trim[0] = OI; m_trim[1] = GI;
    edges = 0;
    @(negedge clk);
    expect_eq("R1", int'(offset_trim), OI);
    expect_eq("R1", int'(gain_trim), GI);
    expect_eq("R1", int'(cal_done), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int bias [5];
    bias[0] = 50; bias[1] = 30; bias[2] = 70; bias[3] = 95; bias[4] = 5;
    void'($urandom(32'd1305));
    apply_reset();

    // R8: decisions toggle with both valids low, nothing may move
    for (int i = 0; i < 40; i++)
      tick("R8", "R8", 1'b0, 1'($urandom % 2), 1'b0, 1'($urandom % 2));

    // R2: balanced votes never reach the margin
    for (int i = 0; i < 200; i++)
      tick("R2", "R9", 1'b1, 1'(i % 2), 1'b0, 1'b0);

    // R2: fifteen "above" votes stay below the margin; R3: the sixteenth fires
    for (int i = 0; i < 15; i++) tick("R2", "R9", 1'b1, 1'b1, 1'b0, 1'b0);
    tick("R3", "R9", 1'b1, 1'b1, 1'b0, 1'b0);
    expect_eq("R3", int'(offset_trim), OI - 1);

    // R5: drive the offset code into its floor and beyond
    for (int i = 0; i < 64; i++) tick("R5", "R9", 1'b1, 1'b1, 1'b0, 1'b0);
    expect_eq("R5", int'(offset_trim), 0);

    // R3: "below" votes pull the offset code back up
    for (int i = 0; i < 32; i++) tick("R3", "R9", 1'b1, 1'b0, 1'b0, 1'b0);
    expect_eq("R3", int'(offset_trim), 2);

    // R4 and R5: gain code climbs to its ceiling and holds; offset untouched (R9)
    for (int i = 0; i < 80; i++) tick("R9", "R4", 1'b0, 1'b0, 1'b1, 1'b0);
    expect_eq("R5", int'(gain_trim), TOPV);

    // R4: gain "above" votes lower it
    for (int i = 0; i < 16; i++) tick("R9", "R4", 1'b0, 1'b0, 1'b1, 1'b1);
    expect_eq("R4", int'(gain_trim), TOPV - 1);

    // R7: random votes with shifting bias through and past the settle point
    while (edges < NCAL + 800) begin
      int b0 = bias[$urandom % 5];
      int b1 = bias[$urandom % 5];
      for (int i = 0; i < 64; i++)
        tick("R7", "R7",
             1'(($urandom % 4) != 0), 1'(($urandom % 100) < b0),
             1'(($urandom % 4) != 0), 1'(($urandom % 100) < b1));
    end
    expect_eq("R7", (moves_late > 0) ? 1 : 0, 1);

    // R1: reset mid-run restores the start state and restarts the timer
    apply_reset();
    for (int i = 0; i < 5; i++) tick("R1", "R1", 1'b0, 1'b0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule